// File: doc/BRIEF.md
# Vector Lane Predication Block Tracker

This block follows a short run of vector instructions that a prefix instruction has placed under predication. When the prefix issues, the block takes a 4-bit encoded mask and a 16-bit per-byte predicate. From the mask it works out two things: how many of the following instructions belong to the run, and whether each one is a Then slot or an Else slot. Each retire strobe then moves the tracker on by one slot. When the final slot retires, the tracker goes back to idle, and later instructions run unpredicated.

For the instruction that is about to retire, the block drives a byte-enable vector for a 128-bit datapath. It also merges the instruction's result with the prior destination value, byte by byte. A disabled lane either keeps the old destination bytes or is written with zero, and the instruction selects which. A Then slot uses the predicate as it is. An Else slot uses its inverse. The lane width of each instruction (8, 16 or 32 bits) sets which predicate bit governs each byte.

Top module: `vpred_tracker`

## Requirements
- R1: After a synchronous reset, in_block is 0, slot_index is 0, is_else is 0 and mask_err is 0.
- R2: A prefix with a non-zero mask makes in_block 1, slot_index 0 and is_else 0 from the next cycle, so the first slot is always Then.
- R3: Let p be the position of the lowest set bit of the mask. The run then holds 4-p slots. Each retire while in_block advances slot_index by 1, and in_block drops to 0 in the cycle after the last slot (index 3-p) retires. When idle, slot_index and is_else are 0.
- R4: Slot 0 is Then. For k from 1 to 3, slot k is Else exactly when slot k-1 is Else XOR mask bit (4-k).
- R5: A prefix with mask 0 starts no run. It also clears any active run, and mask_err is 1 for exactly the next cycle.
- R6: A prefix issued while a run is active restarts tracking at slot 0 with the new mask and predicate. If a prefix and a retire arrive in the same cycle, the prefix wins.
- R7: In a cycle with neither prefix nor retire, in_block, slot_index and is_else keep their values.
- R8: lane_size 0 means 8-bit lanes, 1 means 16-bit lanes, and 2 or 3 means 32-bit lanes. Byte b is enabled when the predicate bit of the lowest byte of b's lane, XOR is_else, is 1. When in_block is 0, all 16 enables are 1.
- R9: An enabled byte of merged equals result. A disabled byte equals old_dst when merge_mode is 1 and 0 when merge_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prefix_valid | input | 1 | Prefix instruction issued this cycle |
| prefix_mask | input | 4 | Encoded flip/terminator mask |
| prefix_pred | input | 16 | Per-byte lane predicate |
| retire | input | 1 | A vector instruction retires this cycle |
| lane_size | input | 2 | Lane width of the retiring instruction |
| merge_mode | input | 1 | 1 keeps old bytes in disabled lanes, 0 zeroes them |
| old_dst | input | 128 | Prior destination register value |
| result | input | 128 | Unpredicated result of the instruction |
| in_block | output | 1 | Current slot lies inside a predicated run |
| is_else | output | 1 | Current slot is an Else slot |
| slot_index | output | 2 | Index of the current slot |
| lane_en | output | 16 | Byte enables for the current instruction |
| merged | output | 128 | Lane-merged value to write back |
| mask_err | output | 1 | Previous cycle issued an all-zero mask |

## Verification
in_block, is_else and slot_index come from registered state, so they change one clock edge after the prefix or retire that moves them. mask_err likewise rises one cycle after the zero-mask prefix and lasts one cycle. lane_en and merged are combinational: they follow the current state and the inputs applied in the same cycle. The driver applies inputs on the falling edge and, from a reference model, computes what all outputs should be in that same cycle; only after that does the model take the coming rising edge into account. The monitor compares 5 ns after the falling edge, well before the rising edge that would change the state.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
    parameter int VP_DATA_W = 128;
    parameter int VP_MASK_W = 4;

    typedef enum logic [1:0] {
        LSZ_B8     = 2'd0,
        LSZ_B16    = 2'd1,
        LSZ_B32    = 2'd2,
        LSZ_B32ALT = 2'd3
    } lane_sz_e;
endpackage

// File: rtl/vpred_mask_dec.sv
module vpred_mask_dec #(
    parameter int MASK_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic [MASK_W-1:0] mask,
    output logic              legal,
    output logic [IDX_W-1:0]  last_idx,
    output logic [MASK_W-1:0] else_pat
);
    always_comb begin
        legal    = |mask;
        last_idx = '0;
        // lowest set bit is the terminator; scanning downward lets it win
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (mask[i]) last_idx = IDX_W'(MASK_W - 1 - i);
        end
        // each lower slot flips relative to its predecessor when its bit is set
        else_pat    = '0;
        for (int k = 1; k < MASK_W; k++) begin
            else_pat[k] = else_pat[k-1] ^ mask[MASK_W-k];
        end
    end
endmodule

// File: rtl/vpred_lane_en.sv
module vpred_lane_en #(
    parameter int NB = 16
) (
    input  logic [NB-1:0] pred,
    input  logic          invert,
    input  logic          active,
    input  logic [1:0]    lsz,
    output logic [NB-1:0] en
);
    import vpred_pkg::*;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int L16 = b - (b % 2);
        localparam int L32 = b - (b % 4);
        logic sel;
        always_comb begin
            case (lsz)
                LSZ_B8:  sel = pred[b];
                LSZ_B16: sel = pred[L16];
                default: sel = pred[L32];
            endcase
        end
        assign en[b] = !active | (sel ^ invert);
    end
endmodule

// File: rtl/vpred_merge.sv
module vpred_merge #(
    parameter int NB = 16
) (
    input  logic [NB-1:0]   en,
    input  logic            keep_old,
    input  logic [NB*8-1:0] old_val,
    input  logic [NB*8-1:0] new_val,
    output logic [NB*8-1:0] out_val
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign out_val[b*8 +: 8] = en[b]    ? new_val[b*8 +: 8] :
                                   keep_old ? old_val[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/vpred_tracker.sv
module vpred_tracker #(
    parameter int DATA_W = vpred_pkg::VP_DATA_W,
    parameter int MASK_W = vpred_pkg::VP_MASK_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prefix_valid,
    input  logic [MASK_W-1:0]        prefix_mask,
    input  logic [DATA_W/8-1:0]      prefix_pred,
    input  logic                     retire,
    input  logic [1:0]               lane_size,
    input  logic                     merge_mode,
    input  logic [DATA_W-1:0]        old_dst,
    input  logic [DATA_W-1:0]        result,
    output logic                     in_block,
    output logic                     is_else,
    output logic [$clog2(MASK_W)-1:0] slot_index,
    output logic [DATA_W/8-1:0]      lane_en,
    output logic [DATA_W-1:0]        merged,
    output logic                     mask_err
);
    localparam int NB    = DATA_W / 8;
    localparam int IDX_W = $clog2(MASK_W);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  slot;
        logic [IDX_W-1:0]  last;
        logic [MASK_W-1:0] else_pat;
        logic [NB-1:0]     pred;
        logic              err;
    } trk_t;

    trk_t st_d, st_q;

    logic              dec_legal;
    logic [IDX_W-1:0]  dec_last;
    logic [MASK_W-1:0] dec_else;

    vpred_mask_dec #(.MASK_W(MASK_W), .IDX_W(IDX_W)) u_dec (
        .mask     (prefix_mask),
        .legal    (dec_legal),
        .last_idx (dec_last),
        .else_pat (dec_else)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (prefix_valid) begin
            st_d.slot = '0;
            if (!dec_legal) begin
                st_d.active = 1'b0;
                st_d.err    = 1'b1;
            end else begin
                st_d.active   = 1'b1;
                st_d.last     = dec_last;
                st_d.else_pat = dec_else;
                st_d.pred     = prefix_pred;
            end
        end else if (retire && st_q.active) begin
            if (st_q.slot == st_q.last) begin
                st_d.active = 1'b0;
                st_d.slot   = '0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_block   = st_q.active;
    assign slot_index = st_q.slot;
    assign is_else    = st_q.active & st_q.else_pat[st_q.slot];
    assign mask_err   = st_q.err;

    vpred_lane_en #(.NB(NB)) u_en (
        .pred   (st_q.pred),
        .invert (is_else),
        .active (st_q.active),
        .lsz    (lane_size),
        .en     (lane_en)
    );

    vpred_merge #(.NB(NB)) u_merge (
        .en       (lane_en),
        .keep_old (merge_mode),
        .old_val  (old_dst),
        .new_val  (result),
        .out_val  (merged)
    );
endmodule

// File: rtl/vpred_tracker_chk.sv
module vpred_tracker_chk #(
    parameter int DATA_W = 128,
    parameter int MASK_W = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      prefix_valid,
    input logic [MASK_W-1:0]         prefix_mask,
    input logic                      retire,
    input logic                      merge_mode,
    input logic [DATA_W-1:0]         old_dst,
    input logic [DATA_W-1:0]         result,
    input logic                      in_block,
    input logic                      is_else,
    input logic [$clog2(MASK_W)-1:0] slot_index,
    input logic [DATA_W/8-1:0]       lane_en,
    input logic [DATA_W-1:0]         merged,
    input logic                      mask_err
);
    localparam int NB = DATA_W / 8;

    // R2
    start_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (prefix_valid && (prefix_mask != '0)) |=> (in_block && slot_index == '0 && !is_else));

    // R4
    first_then_chk: assert property (@(posedge clk) disable iff (rst)
        (in_block && slot_index == '0) |-> !is_else);

    // R5
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (prefix_valid && (prefix_mask == '0)) |=> (mask_err && !in_block));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!prefix_valid && retire && in_block) |=>
            (!in_block || slot_index == $past(slot_index) + 1'b1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!prefix_valid && !retire) |=>
            ($stable(in_block) && $stable(slot_index) && $stable(is_else) && !mask_err));

    // R8
    idle_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !in_block |-> (&lane_en));

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // R9
        pass_byte_chk: assert property (@(posedge clk) disable iff (rst)
            lane_en[b] |-> (merged[b*8 +: 8] == result[b*8 +: 8]));
        // R9
        keep_byte_chk: assert property (@(posedge clk) disable iff (rst)
            (!lane_en[b] && merge_mode) |-> (merged[b*8 +: 8] == old_dst[b*8 +: 8]));
        // R9
        zero_byte_chk: assert property (@(posedge clk) disable iff (rst)
            (!lane_en[b] && !merge_mode) |-> (merged[b*8 +: 8] == 8'h00));
    end
endmodule

bind vpred_tracker vpred_tracker_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .prefix_valid (prefix_valid),
    .prefix_mask  (prefix_mask),
    .retire       (retire),
    .merge_mode   (merge_mode),
    .old_dst      (old_dst),
    .result       (result),
    .in_block     (in_block),
    .is_else      (is_else),
    .slot_index   (slot_index),
    .lane_en      (lane_en),
    .merged       (merged),
    .mask_err     (mask_err)
);

// File: tb/vpred_tracker_tb.sv
module vpred_tracker_tb;
    localparam int DATA_W = 128;
    localparam int NB     = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prefix_valid = 1'b0;
    logic [3:0]        prefix_mask = '0;
    logic [NB-1:0]     prefix_pred = '0;
    logic              retire = 1'b0;
    logic [1:0]        lane_size = '0;
    logic              merge_mode = 1'b0;
    logic [DATA_W-1:0] old_dst = '0;
    logic [DATA_W-1:0] result = '0;
    logic              in_block, is_else, mask_err;
    logic [1:0]        slot_index;
    logic [NB-1:0]     lane_en;
    logic [DATA_W-1:0] merged;

    always #10 clk = ~clk;

    vpred_tracker u_dut (
        .clk(clk), .rst(rst), .prefix_valid(prefix_valid), .prefix_mask(prefix_mask),
        .prefix_pred(prefix_pred), .retire(retire), .lane_size(lane_size),
        .merge_mode(merge_mode), .old_dst(old_dst), .result(result),
        .in_block(in_block), .is_else(is_else), .slot_index(slot_index),
        .lane_en(lane_en), .merged(merged), .mask_err(mask_err)
    );

    typedef struct {
        logic              blk;
        logic              els;
        logic [1:0]        slot;
        logic [NB-1:0]     en;
        logic [DATA_W-1:0] mrg;
        logic              err;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference model
    bit          m_active = 0;
    int          m_slot   = 0;
    int          m_len    = 0;
    bit          m_else [4];
    logic [NB-1:0] m_pred = '0;
    bit          m_err    = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic drive(input logic pv, input logic [3:0] mk, input logic [NB-1:0] pd,
                         input logic rt, input logic [1:0] ls, input logic mm,
                         input logic [DATA_W-1:0] od, input logic [DATA_W-1:0] rs,
                         input string req);
        exp_t e;
        int   lb;
        @(negedge clk);
        prefix_valid = pv; prefix_mask = mk; prefix_pred = pd; retire = rt;
        lane_size = ls; merge_mode = mm; old_dst = od; result = rs;
        e.blk  = m_active;
        e.slot = m_active ? 2'(m_slot) : 2'd0;
        e.els  = m_active ? m_else[m_slot] : 1'b0;
        e.err  = m_err;
        e.req  = req;
        lb = (ls == 2'd0) ? 1 : (ls == 2'd1) ? 2 : 4;
        for (int b = 0; b < NB; b++) begin
            int lo;
            lo = b - (b % lb);
            e.en[b] = m_active ? (m_pred[lo] ^ e.els) : 1'b1;
            e.mrg[b*8 +: 8] = e.en[b] ? rs[b*8 +: 8] : (mm ? od[b*8 +: 8] : 8'h00);
        end
        exp_q.push_back(e);
        // model the coming rising edge
        if (pv) begin
            m_slot = 0;
            if (mk == 4'd0) begin
                m_active = 0; m_err = 1;
            end else begin
                int p;
                p = 0;
                for (int i = 3; i >= 0; i--) if (mk[i]) p = i;
                m_len = 4 - p;
                m_else[0] = 0;
                for (int k = 1; k < 4; k++) m_else[k] = m_else[k-1] ^ mk[4-k];
                m_pred = pd; m_active = 1; m_err = 0;
            end
        end else begin
            m_err = 0;
            if (rt && m_active) begin
                if (m_slot == m_len - 1) begin m_active = 0; m_slot = 0; end
                else m_slot = m_slot + 1;
            end
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (in_block !== e.blk || is_else !== e.els || slot_index !== e.slot ||
                    lane_en !== e.en || merged !== e.mrg || mask_err !== e.err) begin
                    n_fail++;
                    $display("FAIL %s: actual blk=%0b else=%0b slot=%0d en=%h err=%0b mrg=%h expected blk=%0b else=%0b slot=%0d en=%h err=%0b mrg=%h",
                             e.req, in_block, is_else, slot_index, lane_en, mask_err, merged,
                             e.blk, e.els, e.slot, e.en, e.err, e.mrg);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [DATA_W-1:0] OLDV = {16{8'hA5}};
    localparam logic [DATA_W-1:0] RESV = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 R8: idle after reset, all lanes enabled
        drive(0, 4'h0, '0, 0, 2'd0, 0, OLDV, RESV, "R1");
        drive(0, 4'h0, '0, 1, 2'd2, 1, OLDV, RESV, "R8");
        // one-slot run
        drive(1, 4'b1000, 16'h00FF, 0, 2'd0, 1, OLDV, RESV, "R1");
        drive(0, 4'h0, '0, 1, 2'd0, 1, OLDV, RESV, "R2 R9");
        drive(0, 4'h0, '0, 0, 2'd0, 0, OLDV, RESV, "R3");
        // four slots: T E E T
        drive(1, 4'b1011, 16'h1234, 0, 2'd0, 0, OLDV, RESV, "R3");
        drive(0, 4'h0, '0, 1, 2'd1, 0, OLDV, RESV, "R2 R8 R9");
        drive(0, 4'h0, '0, 0, 2'd1, 1, OLDV, RESV, "R7");
        drive(0, 4'h0, '0, 1, 2'd2, 1, OLDV, RESV, "R4 R8");
        drive(0, 4'h0, '0, 1, 2'd0, 0, OLDV, RESV, "R4");
        drive(0, 4'h0, '0, 1, 2'd3, 1, OLDV, RESV, "R4 R8");
        drive(0, 4'h0, '0, 0, 2'd0, 1, OLDV, RESV, "R3");
        // three slots: T T E, cut short by a zero mask
        drive(1, 4'b0110, 16'hF0F0, 0, 2'd0, 0, OLDV, RESV, "R3");
        drive(0, 4'h0, '0, 1, 2'd0, 1, OLDV, RESV, "R2");
        drive(0, 4'h0, '0, 1, 2'd1, 0, OLDV, RESV, "R4");
        drive(1, 4'b0000, 16'hFFFF, 1, 2'd0, 1, OLDV, RESV, "R4");
        drive(0, 4'h0, '0, 0, 2'd0, 0, OLDV, RESV, "R5");
        drive(0, 4'h0, '0, 0, 2'd0, 0, OLDV, RESV, "R5");
        // restart with prefix and retire together
        drive(1, 4'b0001, 16'h0F0F, 0, 2'd0, 0, OLDV, RESV, "R6");
        drive(0, 4'h0, '0, 1, 2'd0, 0, OLDV, RESV, "R6");
        drive(1, 4'b1100, 16'hFF00, 1, 2'd1, 1, OLDV, RESV, "R6");
        drive(0, 4'h0, '0, 1, 2'd0, 0, OLDV, RESV, "R6");
        drive(0, 4'h0, '0, 1, 2'd2, 1, OLDV, RESV, "R6 R4");
        drive(0, 4'h0, '0, 1, 2'd0, 0, OLDV, RESV, "R3");
        // reset in the middle of a run
        drive(1, 4'b0001, 16'h5555, 0, 2'd0, 0, OLDV, RESV, "R6");
        @(negedge clk);
        prefix_valid = 0; retire = 0; rst = 1;
        m_active = 0; m_slot = 0; m_err = 0;
        @(negedge clk);
        rst = 0;
        drive(0, 4'h0, '0, 0, 2'd0, 0, OLDV, RESV, "R1");
        drive(0, 4'h0, '0, 0, 2'd0, 0, OLDV, RESV, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule